// File: doc/BRIEF.md
# Cascade Frame-Sync DAC Update Counter

This block lives inside one codec of a daisy chain of serial codecs that share a single frame sync. Every frame, a new 16-bit word arrives in the codec's serial input register. When several codecs are chained, the word meant for this device is only complete after one frame per device has gone by. So the block counts rising edges of frame sync and copies the serial input register into the DAC holding register only on the frame that closes a full pass through the chain.

A 3-bit device-count field sets the chain length. The field holds the number of chained devices minus one, so a value of 0 gives one device and a value of 7 gives eight. A single codec leaves the field at its reset value of 0 and updates on every frame. The block samples a new field value only when a pass through the chain ends, so a value written halfway through a pass never cuts that pass short.

Everything runs on the serial clock with a synchronous active-high reset. Both outputs come straight from registers.

Top module: `casc_dac_update`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dac_value` is 0 and `dac_load` is 0. After reset the effective chain length is one device, whatever value `dev_cnt` holds, until the first load.
- R2: A frame is counted on a rising edge of `fsync` only, that is `fsync` high at a clock edge where it was low at the previous edge. A frame sync held high for many cycles counts once. A frame sync that is already high when reset releases is not counted.
- R3: With effective field value k, where `dev_cnt` is binary and k runs from 0 to 7, a load happens on every (k+1)-th counted frame. With k = 0 every frame loads.
- R4: All eight chain lengths are supported. With k = 7, exactly one load happens per 8 counted frames, and the count wraps without overflow.
- R5: After each load the frame count restarts from zero. The next load comes after exactly k+1 further frames, where k is the field value that applies to the new pass.
- R6: `dev_cnt` is sampled only in the cycle that performs a load. A change made mid-pass has no effect until the pass that follows the next load.
- R7: `dac_load` is high for exactly one cycle, the cycle after the clock edge at which the closing `fsync` rise is first sampled. `dac_value` takes its new value in that same cycle.
- R8: The value loaded is the last word captured by `word_vld` before the closing frame edge. A word captured in the same cycle as that edge is not used by this load; it is kept for the next one.
- R9: `dac_value` does not change in any cycle in which `dac_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous reset, active high |
| fsync | input | 1 | Frame sync from the chain |
| word_vld | input | 1 | One-cycle strobe: a received word is complete |
| word_data | input | DATA_W (16) | Received word, valid with `word_vld` |
| dev_cnt | input | CNT_W (3) | Chain length minus one |
| dac_value | output | DATA_W (16) | DAC holding register |
| dac_load | output | 1 | One-cycle strobe marking a DAC register load |

## Verification
The in-RTL assertions are checked on every cycle. They cover these behaviours:
- `dac_value` holds steady unless `dac_load` is high.
- A load carries the serial input register's previous value.
- `dac_load` never lasts two cycles and always follows a detected frame edge.
- The frame count stays within the latched length.
- The latched length changes only at a load.

Some properties depend on a sequence of frames, so only the bench's scenarios can show them. These are the exact number of loads per pass for each chain length, the delayed effect of a mid-pass change to `dev_cnt`, a long-held or reset-spanning frame sync, and a word arriving in the same cycle as the closing edge. A behavioural model also tracks the outputs and compares them on every clock.

// File: rtl/casc_pkg.sv
`timescale 1ns/1ps
package casc_pkg;
  localparam int DATA_W_DEF = 16;
  localparam int CNT_W_DEF  = 3;
endpackage

// File: rtl/casc_fs_edge.sv
`timescale 1ns/1ps
module casc_fs_edge (
  input  logic clk,
  input  logic rst,
  input  logic fs_i,
  output logic rise_o
);
  logic fs_q;

  // Resets high so a sync already high at reset release is not a rise.
  always_ff @(posedge clk) begin
    if (rst) fs_q <= 1'b1;
    else     fs_q <= fs_i;
  end

  assign rise_o = fs_i & ~fs_q;

  // Two rises can never be seen back to back.
  AST_RISE_GAP: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/casc_frame_ctr.sv
`timescale 1ns/1ps
module casc_frame_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cfg_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;

  assign wrap_o = rise_i && (cnt_q == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (rise_i) begin
      if (cnt_q == act_q) begin
        cnt_q <= '0;
        act_q <= cfg_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= act_q); // R4
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> $stable(act_q)); // R6
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> cnt_q == '0); // R5
endmodule

// File: rtl/casc_dac_path.sv
`timescale 1ns/1ps
module casc_dac_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              load_o
);
  logic [DATA_W-1:0] in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= '0;
      dac_o  <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= load_i;
      if (load_i)     dac_o <= in_q;
      if (word_vld_i) in_q  <= word_i;
    end
  end

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_o |-> $stable(dac_o)); // R9
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (rst)
    load_o |-> dac_o == $past(in_q)); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o); // R7
endmodule

// File: rtl/casc_dac_update.sv
`timescale 1ns/1ps
module casc_dac_update
  import casc_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int CNT_W  = CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word_data,
  input  logic [CNT_W-1:0]  dev_cnt,
  output logic [DATA_W-1:0] dac_value,
  output logic              dac_load
);
  logic rise;
  logic wrap;

  casc_fs_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .fs_i   (fsync),
    .rise_o (rise)
  );

  casc_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise),
    .cfg_i  (dev_cnt),
    .wrap_o (wrap)
  );

  casc_dac_path #(.DATA_W(DATA_W)) u_path (
    .clk        (clk),
    .rst        (rst),
    .word_vld_i (word_vld),
    .word_i     (word_data),
    .load_i     (wrap),
    .dac_o      (dac_value),
    .load_o     (dac_load)
  );

  AST_LOAD_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    dac_load |-> $past(rise)); // R2
endmodule

// File: tb/sim_casc_dac_update.sv
`timescale 1ns/1ps
module sim_casc_dac_update;
  localparam int DW = 16;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fsync = 1'b0;
  logic          word_vld = 1'b0;
  logic [DW-1:0] word_data = '0;
  logic [CW-1:0] dev_cnt = '0;
  logic [DW-1:0] dac_value;
  logic          dac_load;

  int compared = 0;
  int mismatched = 0;
  int obs_loads = 0;

  always #10 clk = ~clk;

  casc_dac_update #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .fsync(fsync), .word_vld(word_vld),
    .word_data(word_data), .dev_cnt(dev_cnt),
    .dac_value(dac_value), .dac_load(dac_load)
  );

  // Behavioural reference model
  int m_prev, m_cnt, m_len, m_in, m_dac, m_load;
  always @(posedge clk) begin
    if (rst) begin
      m_prev = 1; m_cnt = 0; m_len = 1; m_in = 0; m_dac = 0; m_load = 0;
    end else begin
      m_load = 0;
      if (fsync && m_prev == 0) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == m_len) begin
          m_dac = m_in; m_load = 1; m_cnt = 0; m_len = int'(dev_cnt) + 1;
        end
      end
      if (word_vld) m_in = int'(word_data);
      m_prev = int'(fsync);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (dac_load) obs_loads++;
    chk("R8 dac_value vs model", int'(dac_value), m_dac);
    chk("R7 dac_load vs model", int'(dac_load), m_load);
  end

  task automatic frame(input logic [DW-1:0] w, input int hold);
    @(negedge clk); word_vld = 1'b1; word_data = w;
    @(negedge clk); word_vld = 1'b0; fsync = 1'b1;
    repeat (hold) @(negedge clk);
    fsync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frames(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) frame(base + DW'(i), 1);
  endtask

  task automatic run_all();
    int l0;
    // R1: reset state, nonzero field ignored for first pass
    dev_cnt = 3'd3;
    repeat (4) @(negedge clk);
    chk("R1 reset dac_value", int'(dac_value), 0);
    chk("R1 reset dac_load", int'(dac_load), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset dac_value", int'(dac_value), 0);
    l0 = obs_loads; frame(16'hA001, 1);
    chk("R1 first frame loads", obs_loads - l0, 1);
    chk("R8 first load value", int'(dac_value), 16'hA001);
    // R3: field 3 -> one load per 4 frames
    l0 = obs_loads; frames(8, 16'h1000);
    chk("R3 loads for 8 frames, k=3", obs_loads - l0, 2);
    chk("R8 value after pass", int'(dac_value), 16'h1007);
    // R6: mid-pass change
    l0 = obs_loads; frames(2, 16'h2000); dev_cnt = 3'd0; frames(1, 16'h2100);
    chk("R6 no early load after change", obs_loads - l0, 0);
    frames(1, 16'h2200);
    chk("R6 old length completes pass", obs_loads - l0, 1);
    l0 = obs_loads; frames(3, 16'h2300);
    chk("R6 new length applies", obs_loads - l0, 3);
    // R4/R5: eight devices
    dev_cnt = 3'd7;
    l0 = obs_loads; frames(1, 16'h3000);
    chk("R5 load latching k=7", obs_loads - l0, 1);
    l0 = obs_loads; frames(16, 16'h3100);
    chk("R4 two loads per 16 frames, k=7", obs_loads - l0, 2);
    l0 = obs_loads; frames(7, 16'h3200);
    chk("R5 none before eighth frame", obs_loads - l0, 0);
    dev_cnt = 3'd0;
    frames(1, 16'h3300);
    chk("R5 load on eighth frame", obs_loads - l0, 1);
    // R2: long frame sync counts once
    l0 = obs_loads; frame(16'h4000, 10);
    chk("R2 held sync one load", obs_loads - l0, 1);
    // R2: sync high across reset release
    @(negedge clk); fsync = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; l0 = obs_loads;
    repeat (5) @(negedge clk);
    fsync = 1'b0; repeat (2) @(negedge clk);
    chk("R2 sync across reset not counted", obs_loads - l0, 0);
    // R8: word in same cycle as edge
    frame(16'h1111, 1);
    @(negedge clk); word_vld = 1'b1; word_data = 16'h2222; fsync = 1'b1;
    @(negedge clk); word_vld = 1'b0;
    chk("R7 load strobe in cycle after edge", int'(dac_load), 1);
    chk("R8 same-cycle word not used", int'(dac_value), 16'h1111);
    @(negedge clk); fsync = 1'b0;
    chk("R7 strobe one cycle", int'(dac_load), 0);
    chk("R9 value held", int'(dac_value), 16'h1111);
    repeat (2) @(negedge clk);
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
    chk("R8 kept word used next", int'(dac_value), 16'h2222);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule